// File: doc/BRIEF.md
# Stall and Squash Hazard Controller

This block is the central steering logic for an in-order pipeline with five stages: fetch, decode, execute, memory and write-back. Each cycle it reads the source register numbers of the instruction in decode. It also reads the destination, write-enable and load flag of the instructions in execute and memory, the branch kind and outcome in execute, and return flags in decode and execute. From these it decides how every pipeline register is to be loaded at the coming clock edge. The pipeline has no forwarding paths, so every hazard is resolved by holding instructions in place or by turning them into invalid no-op entries (bubbles).

Conditional branches are predicted taken. A branch found in execute to be not taken cancels the two younger instructions by loading bubbles into decode and execute, and it steers fetch to the fall-through address. A return seen in decode voids one fetch slot. A cycle later, while the return is in execute, fetch is steered to the return address. A data dependence stalls fetch and decode and sends a bubble into execute until the producer has reached write-back. The register file writes before it reads, so a producer in write-back no longer needs a stall.

All outputs are combinational functions of the current stage status and take effect at the next rising edge of the pipeline clock.

Top module: `hazard_ctl`

## Requirements
- R1: When decode reads a used source register (not the zero register) that a valid, writing, non-load instruction in execute will write, stall_f, stall_d and bubble_x are 1 and hz_kind is 1 (def-use).
- R2: When any matching producer in execute or memory is a load, hz_kind is 2 (load-use), with the same stall pattern as R1.
- R3: A matching writer in memory also stalls. A producer that has reached write-back or left the pipeline (distance 3 or more) causes no stall.
- R4: No stall arises from register 31 (the zero register), from a source whose use flag is 0, from a producer with valid or write-enable low, or when decode holds no valid instruction.
- R5: A valid conditional branch in execute with x_taken = 0 gives bubble_d = 1, bubble_x = 1, pc_sel = 1 (fall-through) and no stall.
- R6: A valid conditional branch in execute with x_taken = 1 causes no bubble, no stall and pc_sel = 0.
- R7: A valid return in decode that is neither stalled nor squashed gives bubble_f = 1 in that cycle only, with pc_sel = 0.
- R8: A valid return in execute gives pc_sel = 2 (return address), unless a squash is under way.
- R9: A squash overrides a data stall and a return bubble: stall_f, stall_d and bubble_f are 0 and hz_kind is 0. A data stall overrides the return bubble: bubble_f is 0.
- R10: With no valid instruction in any stage, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| d_valid | input | 1 | Decode holds a real instruction |
| d_src_a | input | REG_W | First source register number in decode |
| d_use_a | input | 1 | First source is read |
| d_src_b | input | REG_W | Second source register number in decode |
| d_use_b | input | 1 | Second source is read |
| d_is_ret | input | 1 | Decode instruction is a return |
| x_valid | input | 1 | Execute holds a real instruction |
| x_wr_en | input | 1 | Execute instruction writes a register |
| x_dst | input | REG_W | Destination register in execute |
| x_is_load | input | 1 | Execute instruction is a load |
| x_is_bcond | input | 1 | Execute instruction is a conditional branch |
| x_taken | input | 1 | Resolved outcome of that branch |
| x_is_ret | input | 1 | Execute instruction is a return |
| m_valid | input | 1 | Memory stage holds a real instruction |
| m_wr_en | input | 1 | Memory-stage instruction writes a register |
| m_dst | input | REG_W | Destination register in memory stage |
| m_is_load | input | 1 | Memory-stage instruction is a load |
| stall_f | output | 1 | Hold the fetch PC |
| stall_d | output | 1 | Hold the decode register |
| bubble_f | output | 1 | Void this fetch slot (decode receives a bubble) |
| bubble_d | output | 1 | Load a bubble into decode |
| bubble_x | output | 1 | Load a bubble into execute |
| pc_sel | output | 2 | Next PC: 0 predicted, 1 fall-through, 2 return address |
| hz_kind | output | 2 | Data hazard class: 0 none, 1 def-use, 2 load-use |

## Verification
The checker assumes that each stage holds at most one instruction, so execute never flags a conditional branch and a return together. It also assumes that decode carries no valid instruction behind a return that has just reached execute, because the return's fetch bubble filled that slot. The directed stimulus keeps to both assumptions. Branch, return and data-dependence cases are combined only where the pipeline could present them together, such as a squash that lands on a stalled consumer or a return in decode that waits on a data stall.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

  typedef enum logic [1:0] {
    PC_NEXT     = 2'd0,
    PC_FALLTHRU = 2'd1,
    PC_RETADDR  = 2'd2
  } pc_sel_e;

  typedef enum logic [1:0] {
    HZ_NONE     = 2'd0,
    HZ_DEF_USE  = 2'd1,
    HZ_LOAD_USE = 2'd2
  } hz_kind_e;

  // producers that can still hold a pending write: execute, memory
  localparam int unsigned NUM_PROD = 2;
  // source operands read in decode
  localparam int unsigned NUM_SRC  = 2;

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned ZERO_REG = 31
) (
  input  logic [REG_W-1:0] src,
  input  logic             src_used,
  input  logic             prod_live,
  input  logic [REG_W-1:0] prod_dst,
  output logic             hit
);

  localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

  always_comb begin
    hit = src_used && prod_live && (src != ZR) && (src == prod_dst);
  end

endmodule

// File: rtl/hz_data_detect.sv
module hz_data_detect
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned ZERO_REG = 31,
  parameter int unsigned N_SRC    = NUM_SRC,
  parameter int unsigned N_PROD   = NUM_PROD
) (
  input  logic                         cons_valid,
  input  logic [N_SRC-1:0][REG_W-1:0]  src,
  input  logic [N_SRC-1:0]             src_used,
  input  logic [N_PROD-1:0]            prod_live,
  input  logic [N_PROD-1:0]            prod_load,
  input  logic [N_PROD-1:0][REG_W-1:0] prod_dst,
  output logic                         stall,
  output hz_kind_e                     kind
);

  logic [N_SRC-1:0][N_PROD-1:0] hit_grid;
  logic [N_PROD-1:0]            prod_hit;

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    for (genvar p = 0; p < N_PROD; p++) begin : g_prod
      hz_src_match #(
        .REG_W   (REG_W),
        .ZERO_REG(ZERO_REG)
      ) u_match (
        .src      (src[s]),
        .src_used (src_used[s]),
        .prod_live(prod_live[p]),
        .prod_dst (prod_dst[p]),
        .hit      (hit_grid[s][p])
      );
    end
  end

  always_comb begin
    prod_hit = '0;
    for (int s = 0; s < N_SRC; s++) begin
      prod_hit = prod_hit | hit_grid[s];
    end
    stall = cons_valid && (|prod_hit);
    if (!stall)                     kind = HZ_NONE;
    else if (|(prod_hit & prod_load)) kind = HZ_LOAD_USE;
    else                            kind = HZ_DEF_USE;
  end

endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter
  import hazard_pkg::*;
(
  input  logic     data_stall,
  input  hz_kind_e data_kind,
  input  logic     squash,
  input  logic     ret_in_d,
  input  logic     ret_in_x,
  output logic     stall_f,
  output logic     stall_d,
  output logic     bubble_f,
  output logic     bubble_d,
  output logic     bubble_x,
  output pc_sel_e  pc_sel,
  output hz_kind_e hz_kind
);

  always_comb begin
    stall_f  = 1'b0;
    stall_d  = 1'b0;
    bubble_f = 1'b0;
    bubble_d = 1'b0;
    bubble_x = 1'b0;
    pc_sel   = PC_NEXT;
    hz_kind  = HZ_NONE;
    if (squash) begin
      // wrong-path fetch and decode slots are cancelled
      bubble_d = 1'b1;
      bubble_x = 1'b1;
      pc_sel   = PC_FALLTHRU;
    end else begin
      if (data_stall) begin
        stall_f  = 1'b1;
        stall_d  = 1'b1;
        bubble_x = 1'b1;
        hz_kind  = data_kind;
      end else if (ret_in_d) begin
        bubble_f = 1'b1;
      end
      if (ret_in_x) pc_sel = PC_RETADDR;
    end
  end

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
  import hazard_pkg::*;
#(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned ZERO_REG = 31
) (
  input  logic             d_valid,
  input  logic [REG_W-1:0] d_src_a,
  input  logic             d_use_a,
  input  logic [REG_W-1:0] d_src_b,
  input  logic             d_use_b,
  input  logic             d_is_ret,
  input  logic             x_valid,
  input  logic             x_wr_en,
  input  logic [REG_W-1:0] x_dst,
  input  logic             x_is_load,
  input  logic             x_is_bcond,
  input  logic             x_taken,
  input  logic             x_is_ret,
  input  logic             m_valid,
  input  logic             m_wr_en,
  input  logic [REG_W-1:0] m_dst,
  input  logic             m_is_load,
  output logic             stall_f,
  output logic             stall_d,
  output logic             bubble_f,
  output logic             bubble_d,
  output logic             bubble_x,
  output logic [1:0]       pc_sel,
  output logic [1:0]       hz_kind
);

  logic [NUM_SRC-1:0][REG_W-1:0]  src_vec;
  logic [NUM_SRC-1:0]             use_vec;
  logic [NUM_PROD-1:0]            live_vec;
  logic [NUM_PROD-1:0]            load_vec;
  logic [NUM_PROD-1:0][REG_W-1:0] dst_vec;
  logic                           data_stall;
  hz_kind_e                       data_kind;
  logic                           squash;
  logic                           ret_in_d;
  logic                           ret_in_x;
  pc_sel_e                        pc_sel_q;
  hz_kind_e                       kind_q;

  always_comb begin
    src_vec  = {d_src_b, d_src_a};
    use_vec  = {d_use_b, d_use_a};
    // index 0: execute, index 1: memory
    live_vec = {m_valid && m_wr_en, x_valid && x_wr_en};
    load_vec = {m_is_load, x_is_load};
    dst_vec  = {m_dst, x_dst};
    squash   = x_valid && x_is_bcond && !x_taken;
    ret_in_d = d_valid && d_is_ret;
    ret_in_x = x_valid && x_is_ret;
  end

  hz_data_detect #(
    .REG_W   (REG_W),
    .ZERO_REG(ZERO_REG),
    .N_SRC   (NUM_SRC),
    .N_PROD  (NUM_PROD)
  ) u_detect (
    .cons_valid(d_valid),
    .src       (src_vec),
    .src_used  (use_vec),
    .prod_live (live_vec),
    .prod_load (load_vec),
    .prod_dst  (dst_vec),
    .stall     (data_stall),
    .kind      (data_kind)
  );

  hz_arbiter u_arb (
    .data_stall(data_stall),
    .data_kind (data_kind),
    .squash    (squash),
    .ret_in_d  (ret_in_d),
    .ret_in_x  (ret_in_x),
    .stall_f   (stall_f),
    .stall_d   (stall_d),
    .bubble_f  (bubble_f),
    .bubble_d  (bubble_d),
    .bubble_x  (bubble_x),
    .pc_sel    (pc_sel_q),
    .hz_kind   (kind_q)
  );

  assign pc_sel  = pc_sel_q;
  assign hz_kind = kind_q;

endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int unsigned REG_W    = 5,
  parameter int unsigned ZERO_REG = 31
) (
  input logic             d_valid,
  input logic [REG_W-1:0] d_src_a,
  input logic             d_use_a,
  input logic [REG_W-1:0] d_src_b,
  input logic             d_use_b,
  input logic             x_valid,
  input logic             x_is_bcond,
  input logic             x_taken,
  input logic             x_is_ret,
  input logic             stall_f,
  input logic             stall_d,
  input logic             bubble_f,
  input logic             bubble_d,
  input logic             bubble_x,
  input logic [1:0]       pc_sel,
  input logic [1:0]       hz_kind
);

  localparam logic [REG_W-1:0] ZR = REG_W'(ZERO_REG);

  always_comb begin
    a_r1_fetch_decode_held_together: assert (stall_f == stall_d);
    a_r3_stall_feeds_x_bubble: assert (!stall_d || bubble_x);
    a_r2_kind_only_when_stalled: assert ((hz_kind != 2'd0) == stall_d);
    a_r4_no_real_source_no_stall: assert (
      (d_valid && ((d_use_a && d_src_a != ZR) || (d_use_b && d_src_b != ZR)))
      || !stall_d);
    a_r5_fallthru_means_squash: assert (
      pc_sel != 2'd1 || (bubble_d && bubble_x && !stall_d));
    a_r6_taken_branch_quiet: assert (
      !(x_valid && x_is_bcond && x_taken) || (pc_sel != 2'd1 && !bubble_d));
    a_r8_ret_in_x_redirects: assert (!(x_valid && x_is_ret) || pc_sel == 2'd2);
    a_r9_ret_bubble_yields: assert (!(bubble_f && (stall_d || bubble_d)));
  end

endmodule

bind hazard_ctl hazard_ctl_chk #(
  .REG_W   (REG_W),
  .ZERO_REG(ZERO_REG)
) u_hazard_ctl_chk (
  .d_valid   (d_valid),
  .d_src_a   (d_src_a),
  .d_use_a   (d_use_a),
  .d_src_b   (d_src_b),
  .d_use_b   (d_use_b),
  .x_valid   (x_valid),
  .x_is_bcond(x_is_bcond),
  .x_taken   (x_taken),
  .x_is_ret  (x_is_ret),
  .stall_f   (stall_f),
  .stall_d   (stall_d),
  .bubble_f  (bubble_f),
  .bubble_d  (bubble_d),
  .bubble_x  (bubble_x),
  .pc_sel    (pc_sel),
  .hz_kind   (hz_kind)
);

// File: tb/test_hazard_ctl.sv
module test_hazard_ctl;

  localparam int unsigned REG_W = 5;

  typedef struct packed {
    logic             d_valid;
    logic [REG_W-1:0] d_src_a;
    logic             d_use_a;
    logic [REG_W-1:0] d_src_b;
    logic             d_use_b;
    logic             d_is_ret;
    logic             x_valid;
    logic             x_wr_en;
    logic [REG_W-1:0] x_dst;
    logic             x_is_load;
    logic             x_is_bcond;
    logic             x_taken;
    logic             x_is_ret;
    logic             m_valid;
    logic             m_wr_en;
    logic [REG_W-1:0] m_dst;
    logic             m_is_load;
  } stim_t;

  // order: stall_f stall_d bubble_f bubble_d bubble_x pc_sel[1:0] hz_kind[1:0]
  typedef struct {
    logic [8:0] val;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  stim_t st = '0;
  logic stall_f, stall_d, bubble_f, bubble_d, bubble_x;
  logic [1:0] pc_sel, hz_kind;
  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hazard_ctl #(.REG_W(REG_W)) i_hazard_ctl (
    .d_valid(st.d_valid), .d_src_a(st.d_src_a), .d_use_a(st.d_use_a),
    .d_src_b(st.d_src_b), .d_use_b(st.d_use_b), .d_is_ret(st.d_is_ret),
    .x_valid(st.x_valid), .x_wr_en(st.x_wr_en), .x_dst(st.x_dst),
    .x_is_load(st.x_is_load), .x_is_bcond(st.x_is_bcond), .x_taken(st.x_taken),
    .x_is_ret(st.x_is_ret), .m_valid(st.m_valid), .m_wr_en(st.m_wr_en),
    .m_dst(st.m_dst), .m_is_load(st.m_is_load),
    .stall_f(stall_f), .stall_d(stall_d), .bubble_f(bubble_f),
    .bubble_d(bubble_d), .bubble_x(bubble_x), .pc_sel(pc_sel), .hz_kind(hz_kind)
  );

  function automatic stim_t consumer(input logic [REG_W-1:0] a, input logic [REG_W-1:0] b);
    stim_t s = '0;
    s.d_valid = 1'b1;
    s.d_src_a = a; s.d_use_a = 1'b1;
    s.d_src_b = b; s.d_use_b = 1'b1;
    return s;
  endfunction

  // driver: applies one cycle of stage status and queues the expected outputs
  task automatic step(input stim_t s, input logic [8:0] e, input string tag);
    exp_t x;
    @(posedge clk);
    #1;
    st = s;
    x.val = e;
    x.tag = tag;
    q.push_back(x);
  endtask

  // monitor: compares at the falling edge, half a cycle after the inputs settle
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t x;
        logic [8:0] got;
        x = q.pop_front();
        got = {stall_f, stall_d, bubble_f, bubble_d, bubble_x, pc_sel, hz_kind};
        checks++;
        if (got !== x.val) begin
          errors++;
          $display("FAIL %s: got %b expected %b", x.tag, got, x.val);
        end
      end
    end
  end

  initial begin
    #(20000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    stim_t s;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R10: empty pipeline
    step('0, 9'b00000_00_00, "R10 idle");

    // R1: back-to-back def-use, producer r3 in execute
    s = consumer(5'd3, 5'd9); s.x_valid = 1; s.x_wr_en = 1; s.x_dst = 5'd3;
    step(s, 9'b11001_00_01, "R1 def-use dist1");
    // R3: same producer now in memory
    s = consumer(5'd3, 5'd9); s.m_valid = 1; s.m_wr_en = 1; s.m_dst = 5'd3;
    step(s, 9'b11001_00_01, "R3 def-use dist2");
    // R3: producer in write-back, no stall
    step(consumer(5'd3, 5'd9), 9'b00000_00_00, "R3 producer in W");

    // R2: load-use distances 1..4 on source b
    s = consumer(5'd7, 5'd5); s.x_valid = 1; s.x_wr_en = 1; s.x_dst = 5'd5; s.x_is_load = 1;
    step(s, 9'b11001_00_10, "R2 load-use dist1");
    s = consumer(5'd7, 5'd5); s.m_valid = 1; s.m_wr_en = 1; s.m_dst = 5'd5; s.m_is_load = 1;
    step(s, 9'b11001_00_10, "R2 load-use dist2");
    step(consumer(5'd7, 5'd5), 9'b00000_00_00, "R3 load-use dist3");
    step(consumer(5'd7, 5'd5), 9'b00000_00_00, "R3 load-use dist4");
    // R2: def in execute and load in memory both match
    s = consumer(5'd4, 5'd6); s.x_valid = 1; s.x_wr_en = 1; s.x_dst = 5'd4;
    s.m_valid = 1; s.m_wr_en = 1; s.m_dst = 5'd6; s.m_is_load = 1;
    step(s, 9'b11001_00_10, "R2 mixed producers");
    // R1: def in memory on source b
    s = consumer(5'd1, 5'd12); s.m_valid = 1; s.m_wr_en = 1; s.m_dst = 5'd12;
    step(s, 9'b11001_00_01, "R1 def-use src b mem");

    // R4: cases that must not stall
    s = consumer(5'd31, 5'd31); s.x_valid = 1; s.x_wr_en = 1; s.x_dst = 5'd31;
    step(s, 9'b00000_00_00, "R4 zero register");
    s = consumer(5'd3, 5'd9); s.d_use_a = 0; s.x_valid = 1; s.x_wr_en = 1; s.x_dst = 5'd3;
    step(s, 9'b00000_00_00, "R4 unused source");
    s = consumer(5'd3, 5'd9); s.x_valid = 1; s.x_wr_en = 0; s.x_dst = 5'd3;
    step(s, 9'b00000_00_00, "R4 no write enable");
    s = consumer(5'd3, 5'd9); s.m_valid = 0; s.m_wr_en = 1; s.m_dst = 5'd9;
    step(s, 9'b00000_00_00, "R4 invalid producer");
    s = consumer(5'd3, 5'd9); s.d_valid = 0; s.x_valid = 1; s.x_wr_en = 1; s.x_dst = 5'd3;
    step(s, 9'b00000_00_00, "R4 decode empty");

    // R5: mispredicted branch
    s = '0; s.x_valid = 1; s.x_is_bcond = 1; s.x_taken = 0;
    step(s, 9'b00011_01_00, "R5 mispredict squash");
    // R6: correctly predicted branch
    s = '0; s.x_valid = 1; s.x_is_bcond = 1; s.x_taken = 1; s.d_valid = 1;
    step(s, 9'b00000_00_00, "R6 taken branch");
    // R9: squash over a data stall on the wrong-path consumer
    s = consumer(5'd8, 5'd2); s.x_valid = 1; s.x_is_bcond = 1; s.x_taken = 0;
    s.m_valid = 1; s.m_wr_en = 1; s.m_dst = 5'd8;
    step(s, 9'b00011_01_00, "R9 squash beats stall");

    // R7 and R8: return passing through decode then execute
    s = '0; s.d_valid = 1; s.d_is_ret = 1;
    step(s, 9'b00100_00_00, "R7 ret in decode");
    s = '0; s.x_valid = 1; s.x_is_ret = 1;
    step(s, 9'b00000_10_00, "R8 ret in execute");
    step('0, 9'b00000_00_00, "R7 single bubble");
    // R9: data stall over return bubble
    s = consumer(5'd30, 5'd31); s.d_is_ret = 1; s.m_valid = 1; s.m_wr_en = 1; s.m_dst = 5'd30;
    step(s, 9'b11001_00_01, "R9 stall beats ret bubble");
    // R9: squash over return bubble
    s = '0; s.d_valid = 1; s.d_is_ret = 1; s.x_valid = 1; s.x_is_bcond = 1;
    step(s, 9'b00011_01_00, "R9 squash beats ret bubble");
    step('0, 9'b00000_00_00, "R10 drained");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule